// File: doc/BRIEF.md
# Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with one transmit pin and one receive pin. A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. A frame-length bit in the control register picks 8 or 9 data bits. A bit-time is `OVS` ticks of an internal oversampling clock. One tick occurs every `TICK_DIV` system clocks.

The CPU reaches the block through a small register port with three locations: a control register, a status register and a data register. Four status flags report on the port: transmit buffer empty, transmit complete, receive buffer full and line idle. Each flag has its own interrupt enable, and the interrupt output is the OR of the enabled flags. The flags behave the same whether the CPU polls them or takes interrupts. A flag clears in two steps: the CPU reads the status register while the flag is set, then accesses the low byte of the data register.

When the transmitter is disabled, the transmit pin is a plain output driven from a control bit. The receive pin can always be read as a plain input through the status register.

Top module: `sci_xcvr`

## Requirements
- R1: After reset, the status register reads 0x0013 while the receive pin is high: buffer empty (bit 0) = 1, complete (bit 1) = 1, receive full (bit 2) = 0, idle (bit 3) = 0, pin (bit 4) = 1. After reset `txd` = 1 and `irq` = 0.
- R2: With transmit enable (control bit 0) set and 9-bit mode (control bit 2) clear, a low-byte data write that completes the two-step clear sends one frame on `txd`. The frame is a 0 start bit, the 8 data bits least significant first, and a 1 stop bit, and each bit lasts `OVS*TICK_DIV` clocks.
- R3: In 9-bit mode, data bit 8 (data register bit 8) is sent after bit 7 and before the stop bit. In 8-bit mode, data bit 8 is not sent and the frame ends after 10 bit-times.
- R4: A frame received with receive enable (control bit 1) set sets receive-full. Its data then reads from data register bits [7:0], and from bit 8 in 9-bit mode. In 8-bit mode, bit 8 reads 0.
- R5: A falling edge on `rxd` starts a frame only if at least 3 high samples came just before it. A start bit that is low in fewer than 2 of the 3 middle samples is dropped.
- R6: Each received bit takes the majority value of its three middle samples. A one-sample glitch does not change the data.
- R7: A frame whose stop bit samples low is discarded and does not set receive-full.
- R8: A flag clears only when a status read that saw it set is followed by a data low-byte access. A data read with no status read before it leaves the flag set.
- R9: If a flag's set condition occurs again between the status read and the data access, the flag stays set.
- R10: Transmit buffer empty clears on the data write and sets again when the shifter takes the data. Transmit complete stays 0 during the frame and sets after the stop bit once the buffer is empty.
- R11: Idle (status bit 3) sets after one full frame time of continuous high input that follows a received frame. After it is cleared, it does not set again until another frame has been received.
- R12: `irq` is 1 exactly when a flag is set and its enable is set. The enables are control bits 3 (buffer empty), 4 (complete), 5 (receive full) and 6 (idle). The flags set and clear the same way whatever the enables are.
- R13: With the transmitter disabled, `txd` follows control bit 7. Status bit 4 shows the synchronized level of `rxd`. With the receiver disabled, no frame is taken in.
- R14: Addresses: 0 = control, 1 = status, 2 = data. `bus_be[0]` selects the low byte and `bus_be[1]` selects the high byte. A data access without `bus_be[0]` starts no transmission and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_be | input | 2 | Byte enables, bit 0 = low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |

## Verification
A wrong bit counter or shift register in the transmitter shows up within one frame: bits appear in the wrong slots, or a ninth bit is added or missing, when `txd` is sampled at each bit center. A broken start qualifier or voter in the receiver shows up after the next frame or glitch: receive-full sets when it should not, or the data register holds a corrupted value. Faulty arm or clear logic is seen on the very next status read, because a flag is still set when the clear should have removed it, or it disappears when it should have stayed. An idle counter that misbehaves shows up one frame time after a received frame.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int F_TDRE = 0;
  localparam int F_TC   = 1;
  localparam int F_RDRF = 2;
  localparam int F_IDLE = 3;
  localparam int NFLAG  = 4;

  localparam int C_TE   = 0;
  localparam int C_RE   = 1;
  localparam int C_M9   = 2;
  localparam int C_TIE  = 3;
  localparam int C_TCIE = 4;
  localparam int C_RIE  = 5;
  localparam int C_ILIE = 6;
  localparam int C_GPO  = 7;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/sci_tick_gen.sv
module sci_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sci_tx.sv
module sci_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       mode9,
  input  logic       have_data,
  input  logic [8:0] data,
  output logic       load,
  output logic       done,
  output logic       line
);
  localparam int PW = $clog2(OVS);
  localparam logic [PW-1:0] PLAST = PW'(OVS - 1);

  logic          busy;
  logic [PW-1:0] ph;
  logic [3:0]    idx;
  logic [3:0]    last_idx;
  logic [10:0]   sh;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy     <= 1'b0;
      ph       <= '0;
      idx      <= '0;
      last_idx <= 4'd9;
      sh       <= '1;
      line     <= 1'b1;
      load     <= 1'b0;
      done     <= 1'b0;
    end else begin
      load <= 1'b0;
      done <= 1'b0;
      if (!busy) begin
        line <= 1'b1;
        if (have_data) begin
          busy     <= 1'b1;
          load     <= 1'b1;
          line     <= 1'b0;
          ph       <= '0;
          idx      <= '0;
          sh       <= mode9 ? {1'b1, data, 1'b0} : {2'b11, data[7:0], 1'b0};
          last_idx <= mode9 ? 4'd10 : 4'd9;
        end
      end else if (tick) begin
        if (ph == PLAST) begin
          ph <= '0;
          if (idx == last_idx) begin
            busy <= 1'b0;
            done <= 1'b1;
            line <= 1'b1;
          end else begin
            idx  <= idx + 1'b1;
            sh   <= {1'b1, sh[10:1]};
            line <= sh[1];
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  // R10: the shifter only takes data the register side offered
  a_r10_load_needs_data: assert property (@(posedge clk) disable iff (rst)
    load |-> $past(have_data));
  // R2: an idle transmitter holds the line high
  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line);
endmodule

// File: rtl/sci_rx.sv
module sci_rx
  import sci_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       en,
  input  logic       mode9,
  input  logic       rx_s,
  output logic       done,
  output logic [8:0] data,
  output logic       idle_evt
);
  localparam int PW = $clog2(OVS);
  localparam int IW = $clog2(OVS * 11 + 1);
  localparam logic [PW-1:0] PLAST = PW'(OVS - 1);
  localparam logic [PW-1:0] V0 = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] V1 = PW'(OVS / 2);
  localparam logic [PW-1:0] V2 = PW'(OVS / 2 + 1);

  rx_state_t     st;
  logic [1:0]    run;
  logic [PW-1:0] ph;
  logic [1:0]    vcnt;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic          armed;
  logic [IW-1:0] icnt;

  logic [1:0]    vsum;
  logic          bitv;
  logic [3:0]    last_idx;
  logic [IW-1:0] flast;

  always_comb begin
    vsum     = vcnt + {1'b0, rx_s};
    bitv     = (vsum >= 2'd2);
    last_idx = mode9 ? 4'd8 : 4'd7;
    flast    = mode9 ? IW'(11 * OVS - 1) : IW'(10 * OVS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st       <= RX_IDLE;
      run      <= '0;
      ph       <= '0;
      vcnt     <= '0;
      idx      <= '0;
      sh       <= '0;
      armed    <= 1'b0;
      icnt     <= '0;
      done     <= 1'b0;
      data     <= '0;
      idle_evt <= 1'b0;
    end else begin
      done     <= 1'b0;
      idle_evt <= 1'b0;
      if (tick) begin
        run <= rx_s ? ((run == 2'd3) ? run : run + 1'b1) : 2'd0;
        if (!rx_s) begin
          icnt <= '0;
        end else if (armed) begin
          if (icnt == flast) begin
            idle_evt <= 1'b1;
            armed    <= 1'b0;
            icnt     <= '0;
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
        case (st)
          RX_IDLE: begin
            if (!rx_s && run == 2'd3) begin
              st   <= RX_START;
              ph   <= PW'(1);
              vcnt <= '0;
            end
          end
          default: begin
            if (ph == V0 || ph == V1) vcnt <= vsum;
            if (ph == V2) begin
              if (st == RX_START && bitv) st <= RX_IDLE;
              if (st == RX_DATA) sh <= {bitv, sh[8:1]};
              if (st == RX_STOP) begin
                st <= RX_IDLE;
                if (bitv) begin
                  done  <= 1'b1;
                  data  <= mode9 ? sh : {1'b0, sh[8:1]};
                  armed <= 1'b1;
                  icnt  <= '0;
                end
              end
            end
            if (ph == PLAST) begin
              ph   <= '0;
              vcnt <= '0;
              if (st == RX_START) begin
                st  <= RX_DATA;
                idx <= '0;
              end else if (st == RX_DATA) begin
                if (idx == last_idx) st <= RX_STOP;
                else idx <= idx + 1'b1;
              end
            end else begin
              ph <= ph + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R5: entry into the start state needs three high samples before the low one
  a_r5_start_after_ones: assert property (@(posedge clk) disable iff (rst)
    (st == RX_START && $past(st) == RX_IDLE) |-> ($past(run) == 2'd3 && !$past(rx_s)));
  // R7: a finished frame can only come from the stop bit
  a_r7_done_from_stop: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st) == RX_STOP);
endmodule

// File: rtl/sci_xcvr.sv
module sci_xcvr
  import sci_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int OVS      = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  input  logic        rxd,
  output logic        txd
);
  localparam logic [NFLAG-1:0] FLAG_RST = 4'b0011;

  logic [1:0]       rsync;
  logic             rx_s;
  logic [7:0]       ctrl;
  logic [8:0]       tdr;
  logic [8:0]       rdr;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] arm;
  logic [NFLAG-1:0] set_ev;
  logic [NFLAG-1:0] ien;
  logic             tick;
  logic             tx_load, tx_done, tx_line;
  logic             rx_done, rx_idle;
  logic [8:0]       rx_data;
  logic             stat_rd, low_acc, data_wr, ctrl_wr;
  logic             unused_wd;

  assign unused_wd = ^bus_wdata[15:9];
  assign rx_s      = rsync[1];

  always_comb begin
    stat_rd = bus_sel && !bus_wr && bus_addr == A_STAT;
    low_acc = bus_sel && bus_addr == A_DATA && bus_be[0];
    data_wr = bus_sel && bus_wr && bus_addr == A_DATA;
    ctrl_wr = bus_sel && bus_wr && bus_addr == A_CTRL && bus_be[0];
    set_ev          = '0;
    set_ev[F_TDRE]  = tx_load;
    set_ev[F_TC]    = tx_done && flags[F_TDRE];
    set_ev[F_RDRF]  = rx_done;
    set_ev[F_IDLE]  = rx_idle;
    ien = {ctrl[C_ILIE], ctrl[C_RIE], ctrl[C_TCIE], ctrl[C_TIE]};
  end

  sci_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  sci_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .en(ctrl[C_TE]), .mode9(ctrl[C_M9]),
    .have_data(!flags[F_TDRE]), .data(tdr),
    .load(tx_load), .done(tx_done), .line(tx_line)
  );

  sci_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .en(ctrl[C_RE]), .mode9(ctrl[C_M9]),
    .rx_s(rx_s), .done(rx_done), .data(rx_data), .idle_evt(rx_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsync <= 2'b11;
      ctrl  <= 8'h80;
      tdr   <= '0;
      rdr   <= '0;
      txd   <= 1'b1;
      irq   <= 1'b0;
    end else begin
      rsync <= {rsync[0], rxd};
      if (ctrl_wr) ctrl <= bus_wdata[7:0];
      if (data_wr && bus_be[0]) tdr[7:0] <= bus_wdata[7:0];
      if (data_wr && bus_be[1]) tdr[8] <= bus_wdata[8];
      if (rx_done) rdr <= rx_data;
      txd <= ctrl[C_TE] ? tx_line : ctrl[C_GPO];
      irq <= |(flags & ien);
    end
  end

  // Two-step clear: arm on a status read that sees the flag, clear on low-byte access
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= FLAG_RST;
      arm   <= '0;
    end else begin
      for (int i = 0; i < NFLAG; i++) begin
        if (set_ev[i]) begin
          flags[i] <= 1'b1;
          arm[i]   <= 1'b0;
        end else if (low_acc) begin
          if (arm[i]) flags[i] <= 1'b0;
          arm[i] <= 1'b0;
        end else if (stat_rd && flags[i]) begin
          arm[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= {8'd0, ctrl};
        A_STAT:  bus_rdata <= {11'd0, rx_s, flags};
        A_DATA:  bus_rdata <= {7'd0, rdr};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R4: a finished frame raises receive-full on the next cycle
  a_r4_rdrf_after_frame: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> flags[F_RDRF]);
  // R8: receive-full only falls after a data low-byte access
  a_r8_rdrf_clear_needs_access: assert property (@(posedge clk) disable iff (rst)
    $fell(flags[F_RDRF]) |-> $past(low_acc));
  // R10: the shifter taking data marks the buffer empty again
  a_r10_tdre_after_load: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> flags[F_TDRE]);
endmodule

// File: tb/sci_xcvr_tb.sv
module sci_xcvr_tb;
  localparam int DIV = 4;
  localparam int OVS = 16;
  localparam int BT  = DIV * OVS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0, bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, txd;
  logic        rx_drv = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sci_xcvr #(.TICK_DIV(DIV), .OVS(OVS)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rxd(rx_drv), .txd(txd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 2'b11;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural line model: drive one frame onto rxd
  task automatic send(input logic [8:0] d, input int nd, input logic stopv, input int gbit);
    logic [10:0] bits;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) bits[i+1] = d[i];
    bits[nd+1] = stopv;
    for (int i = 0; i < nd + 2; i++) begin
      @(negedge clk);
      rx_drv = bits[i];
      if (i == gbit) begin
        waitc(BT / 2 - DIV / 2);
        rx_drv = ~bits[i];
        waitc(DIV);
        rx_drv = bits[i];
        waitc(BT / 2 - DIV / 2 - 1);
      end else begin
        waitc(BT - 1);
      end
    end
    @(negedge clk);
    rx_drv = 1'b1;
  endtask

  task automatic capture(input int n, output logic [10:0] bits);
    bits = '1;
    @(negedge txd);
    waitc(BT / 2);
    bits[0] = txd;
    for (int i = 1; i < n; i++) begin
      waitc(BT);
      bits[i] = txd;
    end
  endtask

  function automatic logic [10:0] tx_model(input logic [8:0] d, input logic m9);
    return m9 ? {1'b1, d, 1'b0} : {2'b11, d[7:0], 1'b0};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [10:0] cap;
    logic        stayed;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    waitc(2);

    // R1 reset state
    rd(2'd1, v);
    chk("R1 status", v, 16'h0013);
    chk("R1 txd", txd, 1'b1);
    chk("R1 irq", irq, 1'b0);

    // R13 pins as plain input / output
    wr(2'd0, 2'b01, 16'h0000);
    waitc(3);
    chk("R13 txd follows gpo", txd, 1'b0);
    rx_drv = 1'b0;
    waitc(4);
    rd(2'd1, v);
    chk("R13 gpi low", v[4], 1'b0);
    rx_drv = 1'b1;
    waitc(4);
    rd(2'd1, v);
    chk("R13 gpi high", v[4], 1'b1);

    // R2 / R10 8-bit transmit
    wr(2'd0, 2'b01, 16'h0081);
    waitc(4);
    fork
      capture(10, cap);
      begin
        rd(2'd1, v);
        wr(2'd2, 2'b01, 16'h00A5);
        waitc(3 * BT);
        rd(2'd1, v);
        chk("R10 mid-frame tdre=1 tc=0", v[1:0], 2'b01);
      end
    join
    chk("R2 frame 0xA5", cap[9:0], tx_model(9'h0A5, 1'b0)[9:0]);
    waitc(BT);
    rd(2'd1, v);
    chk("R10 tc after stop", v[1:0], 2'b11);

    // R3 9-bit transmit
    wr(2'd0, 2'b01, 16'h0085);
    waitc(4);
    fork
      capture(11, cap);
      begin rd(2'd1, v); wr(2'd2, 2'b11, 16'h013C); end
    join
    chk("R3 9-bit frame", cap, tx_model(9'h13C, 1'b1));
    waitc(BT);
    // R3 8-bit mode ignores bit 8: frame ends after 10 bit-times
    wr(2'd0, 2'b01, 16'h0081);
    waitc(4);
    fork
      capture(10, cap);
      begin rd(2'd1, v); wr(2'd2, 2'b11, 16'h0155); end
    join
    chk("R3 8-bit frame", cap[9:0], tx_model(9'h155, 1'b0)[9:0]);
    waitc(BT * 3 / 4);
    rd(2'd1, v);
    chk("R3 no ninth bit", v[1], 1'b1);
    waitc(BT);

    // R14 high-byte-only data write
    rd(2'd1, v);
    wr(2'd2, 2'b10, 16'h01FF);
    stayed = 1'b1;
    for (int i = 0; i < 3 * BT; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) stayed = 1'b0;
    end
    chk("R14 no transmit", stayed, 1'b1);
    rd(2'd1, v);
    chk("R14 flags kept", v[1:0], 2'b11);

    // R4 / R8 receive 8-bit
    wr(2'd0, 2'b01, 16'h0083);
    waitc(BT);
    send(9'h05A, 8, 1'b1, -1);
    rd(2'd2, v);
    chk("R4 data 8-bit", v, 16'h005A);
    rd(2'd1, v);
    chk("R8 not cleared without status read", v[2], 1'b1);
    rd(2'd2, v);
    rd(2'd1, v);
    chk("R8 cleared", v[2], 1'b0);

    // R4 9-bit receive
    wr(2'd0, 2'b01, 16'h0087);
    waitc(BT);
    send(9'h1C3, 9, 1'b1, -1);
    rd(2'd1, v);
    rd(2'd2, v);
    chk("R4 data 9-bit", v, 16'h01C3);

    // R9 set again between the two accesses
    wr(2'd0, 2'b01, 16'h0083);
    waitc(BT);
    send(9'h011, 8, 1'b1, -1);
    rd(2'd1, v);
    send(9'h022, 8, 1'b1, -1);
    rd(2'd2, v);
    chk("R9 newest data", v, 16'h0022);
    rd(2'd1, v);
    chk("R9 rdrf stays", v[2], 1'b1);
    rd(2'd2, v);

    // R6 majority vote against glitches
    send(9'h000, 8, 1'b1, 4);
    rd(2'd1, v);
    rd(2'd2, v);
    chk("R6 glitch on zeros", v, 16'h0000);
    send(9'h0FF, 8, 1'b1, 6);
    rd(2'd1, v);
    rd(2'd2, v);
    chk("R6 glitch on ones", v, 16'h00FF);

    // R5 start qualification
    rx_drv = 1'b0;
    waitc(12 * BT);
    rx_drv = 1'b1;
    waitc(DIV);
    rx_drv = 1'b0;
    waitc(10 * BT);
    rx_drv = 1'b1;
    waitc(2 * BT);
    rd(2'd1, v);
    chk("R5 edge after short high", v[2], 1'b0);
    rx_drv = 1'b0;
    waitc(2 * DIV);
    rx_drv = 1'b1;
    waitc(12 * BT);
    rd(2'd1, v);
    chk("R5 short start rejected", v[2], 1'b0);

    // R7 bad stop bit
    send(9'h03C, 8, 1'b0, -1);
    waitc(2 * BT);
    rd(2'd1, v);
    chk("R7 bad stop discarded", v[2], 1'b0);
    send(9'h03C, 8, 1'b1, -1);
    rd(2'd1, v);
    rd(2'd2, v);
    chk("R7 recovery", v, 16'h003C);

    // R11 idle line
    waitc(12 * BT);
    rd(2'd1, v);
    rd(2'd2, v);
    rd(2'd1, v);
    chk("R11 idle cleared", v[3], 1'b0);
    waitc(12 * BT);
    rd(2'd1, v);
    chk("R11 no rearm without frame", v[3], 1'b0);
    send(9'h077, 8, 1'b1, -1);
    rd(2'd1, v);
    chk("R11 not yet idle", v[3], 1'b0);
    waitc(11 * BT);
    rd(2'd1, v);
    chk("R11 idle set", v[3], 1'b1);

    // R12 interrupt gating
    waitc(2);
    chk("R12 no enables", irq, 1'b0);
    wr(2'd0, 2'b01, 16'h00A3);
    waitc(2);
    chk("R12 rie", irq, 1'b1);
    wr(2'd0, 2'b01, 16'h00C3);
    waitc(2);
    chk("R12 ilie", irq, 1'b1);
    rd(2'd1, v);
    rd(2'd2, v);
    waitc(3);
    chk("R12 ilie after clear", irq, 1'b0);
    wr(2'd0, 2'b01, 16'h008B);
    waitc(2);
    chk("R12 tie", irq, 1'b1);

    summary();
    $finish;
  end
endmodule